// File: doc/BRIEF.md
# Scan-Chain Memory Test Controller

This block gives a tester access to a bank of small on-chip memories through a one-bit serial path. A 112-bit command frame is shifted in while scan enable is high. The frame holds a memory select code and two port descriptors, each with an address, write data, an active-low chip select and an active-low write enable. A low pulse on the global access strobe then runs the command on the selected memory. When the strobe returns high, the read results are captured. A load pulse folds them back into the chain, and raising scan enable again shifts the whole frame out for comparison.

Five dual-port memories and four single-port memories sit behind the select code. All memories are behavioural arrays, 32 bits wide. Only the low address bits are used to index a memory, so an address wraps modulo the memory depth.

Top module: `scan_mem_test`

## Requirements
- R1: Reset (rstN low, asynchronous) clears the chain, both captured read words and every memory word to zero. scanOut is low while reset is held.
- R2: Each clock edge with scanEn high shifts the chain by one position toward the most significant end, taking scanIn into bit 0. scanOut always shows bit 111, so a frame enters and leaves most significant bit first and comes out unchanged when nothing happens in between. The chain holds its value when scanEn is low and no load occurs.
- R3: Frame layout, from bit 111 down: select [111:108], port-0 address [107:92], port-0 data [91:60], port-0 chip select [59], port-0 write enable [58], pad [57:54], port-1 address [53:38], port-1 data [37:6], port-1 chip select [5], port-1 write enable [4], pad [3:0].
- R4: A memory access happens only on a clock edge where accessCsN is low and scanEn is low. A port with chip select 0 and write enable 0 writes its data; a port with chip select 0 and write enable 1 reads. A frame that is shifted in without an access strobe changes no memory.
- R5: On the first edge where accessCsN is high after being low, each port's captured word becomes the word that port read. A port that wrote or was not selected yields zero.
- R6: An edge with loadStb high and scanEn low replaces bits [91:60] with the port-0 captured word and bits [37:6] with the port-1 captured word. Every other bit, including the pads, keeps its value.
- R7: Select codes 0 to 4 address dual-port memories, where both ports act. When both ports write the same word, port 0's data is kept. A read in the same access as a write to the same word returns the old contents.
- R8: Select codes 8 to 11 address single-port memories. These use only the port-0 fields; port-1 fields neither write nor read, and the port-1 captured word is zero.
- R9: Select codes 5 to 7 and 12 to 15 reach no memory. Accesses with them change nothing, and both captured words are zero.
- R10: Each memory holds MEM_DEPTH words that are independent of all other memories. A memory is indexed by the low log2(MEM_DEPTH) address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rstN | input | 1 | Asynchronous active-low reset |
| scanEn | input | 1 | High to shift the chain |
| scanIn | input | 1 | Serial data into bit 0 |
| loadStb | input | 1 | Folds captured read words into the chain |
| accessCsN | input | 1 | Global active-low access strobe, idles high |
| scanOut | output | 1 | Serial data from bit 111 |

## Verification
A shifted bit reaches chain bit 0 on the next edge. The first bit of an outgoing frame is visible as soon as the load edge has passed, and each later bit appears one edge after the one before it. An access takes effect on the single edge where the strobe is low. Capture is due on the next edge, and the load edge follows it. The bench drives every input on the falling edge and moves through that sequence one cycle per step. It samples scanOut at each falling edge before the following shift, so each of the 112 bits is read in the cycle it is due. Each read-back frame is compared whole against a frame the bench builds from the command, with only the two data fields replaced. The inequality it uses treats X as a mismatch.

// File: rtl/smt_pkg.sv
`timescale 1ns/1ps
package smt_pkg;
  localparam int FRAME_W   = 112;
  localparam int SEL_W     = 4;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 32;
  localparam int SEL_LSB   = 108;
  localparam int ADDR0_LSB = 92;
  localparam int DATA0_LSB = 60;
  localparam int CS0_BIT   = 59;
  localparam int WE0_BIT   = 58;
  localparam int ADDR1_LSB = 38;
  localparam int DATA1_LSB = 6;
  localparam int CS1_BIT   = 5;
  localparam int WE1_BIT   = 4;

  typedef struct packed {
    logic shift;
    logic access;
    logic capture;
    logic load;
  } strobe_t;
endpackage

// File: rtl/smt_mem.sv
`timescale 1ns/1ps
module smt_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter bit DUAL   = 1'b1,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              acc,
  input  logic              cs0N,
  input  logic              we0N,
  input  logic [AW-1:0]     addr0,
  input  logic [DATA_W-1:0] wdata0,
  input  logic              cs1N,
  input  logic              we1N,
  input  logic [AW-1:0]     addr1,
  input  logic [DATA_W-1:0] wdata1,
  output logic [DATA_W-1:0] rdata0,
  output logic [DATA_W-1:0] rdata1
);
  logic [DATA_W-1:0] store [DEPTH];
  logic port1On;
  assign port1On = DUAL && !cs1N;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) store[k] <= '0;
      rdata0 <= '0;
      rdata1 <= '0;
    end else if (acc) begin
      rdata0 <= (!cs0N && we0N) ? store[addr0] : '0;
      rdata1 <= (port1On && we1N) ? store[addr1] : '0;
      if (port1On && !we1N) store[addr1] <= wdata1;
      if (!cs0N && !we0N) store[addr0] <= wdata0;   // port 0 wins a collision
    end
  end
endmodule

// File: rtl/smt_ctrl.sv
`timescale 1ns/1ps
module smt_ctrl import smt_pkg::*; (
  input  logic    clk,
  input  logic    rstN,
  input  logic    scanEn,
  input  logic    loadStb,
  input  logic    accessCsN,
  output strobe_t stb
);
  logic csPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csPrev <= 1'b1;
    else       csPrev <= accessCsN;
  end

  always_comb begin
    stb.shift   = scanEn;
    stb.access  = !scanEn && !accessCsN;
    stb.capture = accessCsN && !csPrev;
    stb.load    = !scanEn && loadStb;
  end
endmodule

// File: rtl/smt_datapath.sv
`timescale 1ns/1ps
module smt_datapath import smt_pkg::*; #(
  parameter int MEM_DEPTH   = 8,
  parameter int NUM_DUAL    = 5,
  parameter int NUM_SINGLE  = 4,
  parameter int SINGLE_BASE = 8,
  localparam int MEM_AW     = $clog2(MEM_DEPTH),
  localparam int NUM_MEM    = NUM_DUAL + NUM_SINGLE
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic               scanIn,
  output logic               scanOut,
  output logic [FRAME_W-1:0] frame
);
  logic [FRAME_W-1:0] chain;
  logic [DATA_W-1:0]  held0, held1, pick0, pick1;
  logic [DATA_W-1:0]  q0 [NUM_MEM];
  logic [DATA_W-1:0]  q1 [NUM_MEM];
  logic [NUM_MEM-1:0] hit;
  logic [SEL_W-1:0]   sel;
  logic [MEM_AW-1:0]  a0, a1;

  assign sel = chain[SEL_LSB +: SEL_W];
  assign a0  = chain[ADDR0_LSB +: MEM_AW];
  assign a1  = chain[ADDR1_LSB +: MEM_AW];

  for (genvar g = 0; g < NUM_MEM; g++) begin : gMem
    localparam int  CODE   = (g < NUM_DUAL) ? g : SINGLE_BASE + g - NUM_DUAL;
    localparam bit  IsDual = (g < NUM_DUAL);
    assign hit[g] = (sel == SEL_W'(CODE));
    smt_mem #(.DATA_W(DATA_W), .DEPTH(MEM_DEPTH), .DUAL(IsDual)) uMem (
      .clk(clk), .rstN(rstN), .acc(stb.access && hit[g]),
      .cs0N(chain[CS0_BIT]), .we0N(chain[WE0_BIT]), .addr0(a0),
      .wdata0(chain[DATA0_LSB +: DATA_W]),
      .cs1N(chain[CS1_BIT]), .we1N(chain[WE1_BIT]), .addr1(a1),
      .wdata1(chain[DATA1_LSB +: DATA_W]),
      .rdata0(q0[g]), .rdata1(q1[g]));
  end

  always_comb begin
    pick0 = '0;
    pick1 = '0;
    for (int g = 0; g < NUM_MEM; g++) begin
      if (hit[g]) begin
        pick0 = pick0 | q0[g];
        pick1 = pick1 | q1[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
      held0 <= '0;
      held1 <= '0;
    end else begin
      if (stb.capture) begin
        held0 <= pick0;
        held1 <= pick1;
      end
      if (stb.shift) begin
        chain <= {chain[FRAME_W-2:0], scanIn};
      end else if (stb.load) begin
        chain[DATA0_LSB +: DATA_W] <= held0;
        chain[DATA1_LSB +: DATA_W] <= held1;
      end
    end
  end

  assign scanOut = chain[FRAME_W-1];
  assign frame   = chain;
endmodule

// File: rtl/scan_mem_test.sv
`timescale 1ns/1ps
module scan_mem_test import smt_pkg::*; #(
  parameter int MEM_DEPTH   = 8,
  parameter int NUM_DUAL    = 5,
  parameter int NUM_SINGLE  = 4,
  parameter int SINGLE_BASE = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic scanEn,
  input  logic scanIn,
  input  logic loadStb,
  input  logic accessCsN,
  output logic scanOut
);
  strobe_t            stb;
  logic [FRAME_W-1:0] frame;

  smt_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .loadStb(loadStb),
    .accessCsN(accessCsN), .stb(stb));

  smt_datapath #(
    .MEM_DEPTH(MEM_DEPTH), .NUM_DUAL(NUM_DUAL),
    .NUM_SINGLE(NUM_SINGLE), .SINGLE_BASE(SINGLE_BASE)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .scanIn(scanIn),
    .scanOut(scanOut), .frame(frame));
endmodule

// File: rtl/smt_checker.sv
`timescale 1ns/1ps
module smt_checker import smt_pkg::*; (
  input logic               clk,
  input logic               rstN,
  input logic               scanEn,
  input logic               scanIn,
  input logic               loadStb,
  input logic               accessCsN,
  input logic               scanOut,
  input logic               captureStb,
  input logic [FRAME_W-1:0] frame
);
  always_comb begin
    if (!rstN) AST_RESET_OUT_LOW: assert (!scanOut); // R1
  end

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    scanEn |=> frame[0] == $past(scanIn)); // R2

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    scanEn |=> frame[FRAME_W-1:1] == $past(frame[FRAME_W-2:0])); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!scanEn && !loadStb) |=> $stable(frame)); // R2

  AST_LOAD_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    (!scanEn && loadStb) |=> (frame[111:92] == $past(frame[111:92]))
      && (frame[59:38] == $past(frame[59:38]))
      && (frame[5:0] == $past(frame[5:0]))); // R6

  AST_CAPTURE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    captureStb |-> (accessCsN && !$past(accessCsN))); // R5
endmodule

bind scan_mem_test smt_checker uChk (
  .clk(clk), .rstN(rstN), .scanEn(scanEn), .scanIn(scanIn),
  .loadStb(loadStb), .accessCsN(accessCsN), .scanOut(scanOut),
  .captureStb(stb.capture), .frame(frame));

// File: tb/scan_mem_test_test.sv
`timescale 1ns/1ps
module scan_mem_test_test;
  logic clk = 1'b0;
  logic rstN, scanEn, scanIn, loadStb, accessCsN;
  logic scanOut;
  int   nChecks = 0;
  int   nFails  = 0;
  logic [111:0] got;

  always #2 clk = ~clk;

  scan_mem_test uut (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .scanIn(scanIn),
    .loadStb(loadStb), .accessCsN(accessCsN), .scanOut(scanOut));

  function automatic logic [111:0] mkFrame(
    input logic [3:0] sel, input logic [15:0] ad0, input logic [31:0] d0,
    input logic c0, input logic w0, input logic [3:0] p0,
    input logic [15:0] ad1, input logic [31:0] d1,
    input logic c1, input logic w1, input logic [3:0] p1);
    return {sel, ad0, d0, c0, w0, p0, ad1, d1, c1, w1, p1};
  endfunction

  function automatic logic [111:0] expOf(input logic [111:0] cmd,
                                         input logic [31:0] r0, input logic [31:0] r1);
    logic [111:0] e;
    e = cmd;
    e[91:60] = r0;
    e[37:6]  = r1;
    return e;
  endfunction

  function automatic logic [31:0] dval(input int i);
    return 32'h0F0F0F0F + 32'(i) * 32'h11111111;
  endfunction

  task automatic check(input string tag, input logic [111:0] act, input logic [111:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic shiftIn(input logic [111:0] f);
    scanEn = 1'b1;
    for (int k = 0; k < 112; k++) begin
      scanIn = f[111-k];
      @(negedge clk);
    end
    scanEn = 1'b0;
    scanIn = 1'b0;
  endtask

  task automatic strobe();
    accessCsN = 1'b0;
    @(negedge clk);
    accessCsN = 1'b1;
    @(negedge clk);
  endtask

  task automatic shiftOut(output logic [111:0] r);
    scanEn = 1'b1;
    scanIn = 1'b0;
    for (int k = 0; k < 112; k++) begin
      r[111-k] = scanOut;
      @(negedge clk);
    end
    scanEn = 1'b0;
  endtask

  task automatic doCmd(input logic [111:0] f);
    shiftIn(f);
    strobe();
  endtask

  task automatic readCmd(input logic [111:0] f, output logic [111:0] r);
    doCmd(f);
    loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
    shiftOut(r);
  endtask

  initial begin
    #(4 * 200000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [111:0] cmd;
    rstN = 1'b0; scanEn = 1'b0; scanIn = 1'b0; loadStb = 1'b0; accessCsN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 scanOut in reset", {111'b0, scanOut}, '0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3: a frame passes through unchanged with no access
    cmd = mkFrame(4'h6, 16'hC3A5, 32'h9ABCDEF1, 1'b0, 1'b1, 4'h9,
                  16'h5A3C, 32'h13579BDF, 1'b1, 1'b0, 4'h6);
    shiftIn(cmd);
    @(negedge clk);
    shiftOut(got);
    check("R2 pass-through", got, cmd);

    // R1: memories start at zero
    cmd = mkFrame(4'd3, 16'd5, 32'h0, 1'b0, 1'b1, 4'h5, 16'd5, 32'h0, 1'b0, 1'b1, 4'hA);
    readCmd(cmd, got);
    check("R1 memory zero", got, expOf(cmd, 32'h0, 32'h0));

    // R7: dual-port memories, both ports write, then cross read
    for (int i = 0; i < 5; i++) begin
      doCmd(mkFrame(4'(i), 16'd1, dval(i), 1'b0, 1'b0, 4'hF,
                    16'd2, ~dval(i), 1'b0, 1'b0, 4'hF));
      cmd = mkFrame(4'(i), 16'd2, 32'h0, 1'b0, 1'b1, 4'h5,
                    16'd1, 32'h0, 1'b0, 1'b1, 4'hA);
      readCmd(cmd, got);
      check($sformatf("R7 dual mem %0d", i), got, expOf(cmd, ~dval(i), dval(i)));
    end

    // R8: single-port memories ignore port 1
    for (int j = 8; j < 12; j++) begin
      doCmd(mkFrame(4'(j), 16'd1, 32'hDEAD0000 + 32'(j), 1'b0, 1'b0, 4'hF,
                    16'd1, 32'hFFFF0000, 1'b0, 1'b0, 4'hF));
      cmd = mkFrame(4'(j), 16'd1, 32'h0, 1'b0, 1'b1, 4'h3,
                    16'd1, 32'h0, 1'b0, 1'b1, 4'hC);
      readCmd(cmd, got);
      check($sformatf("R8 single mem %0d", j), got, expOf(cmd, 32'hDEAD0000 + 32'(j), 32'h0));
    end

    // R10: isolation and address wrap
    cmd = mkFrame(4'd0, 16'd1, 32'h0, 1'b0, 1'b1, 4'h1, 16'd9, 32'h0, 1'b0, 1'b1, 4'h2);
    readCmd(cmd, got);
    check("R10 isolation and wrap", got, expOf(cmd, dval(0), dval(0)));

    // R9: unmapped selects
    cmd = mkFrame(4'd5, 16'd1, 32'h12345678, 1'b0, 1'b1, 4'h7, 16'd2, 32'h0, 1'b0, 1'b1, 4'h8);
    readCmd(cmd, got);
    check("R9 select 5 reads zero", got, expOf(cmd, 32'h0, 32'h0));
    doCmd(mkFrame(4'd12, 16'd1, 32'hBAD0BAD0, 1'b0, 1'b0, 4'h0, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0));
    cmd = mkFrame(4'd15, 16'd1, 32'h0, 1'b0, 1'b1, 4'hE, 16'd1, 32'h0, 1'b0, 1'b1, 4'h1);
    readCmd(cmd, got);
    check("R9 select 15 reads zero", got, expOf(cmd, 32'h0, 32'h0));
    cmd = mkFrame(4'd8, 16'd1, 32'h0, 1'b0, 1'b1, 4'h0, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0);
    readCmd(cmd, got);
    check("R9 select 12 wrote nothing", got, expOf(cmd, 32'hDEAD0008, 32'h0));

    // R5: write-only and deselected ports give zero
    cmd = mkFrame(4'd1, 16'd3, 32'h55AA55AA, 1'b0, 1'b0, 4'hB, 16'd1, 32'h77777777, 1'b1, 1'b1, 4'hD);
    readCmd(cmd, got);
    check("R5 write port yields zero", got, expOf(cmd, 32'h0, 32'h0));

    // R4: shifted frame with no strobe writes nothing
    shiftIn(mkFrame(4'd4, 16'd1, 32'hCAFEF00D, 1'b0, 1'b0, 4'h0, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0));
    @(negedge clk);
    cmd = mkFrame(4'd4, 16'd1, 32'h0, 1'b0, 1'b1, 4'h4, 16'd0, 32'h0, 1'b1, 1'b1, 4'h4);
    readCmd(cmd, got);
    check("R4 no strobe no write", got, expOf(cmd, dval(4), 32'h0));

    // R7: collision, port 0 wins
    doCmd(mkFrame(4'd2, 16'd4, 32'h11112222, 1'b0, 1'b0, 4'h0, 16'd4, 32'h33334444, 1'b0, 1'b0, 4'h0));
    cmd = mkFrame(4'd2, 16'd4, 32'h0, 1'b0, 1'b1, 4'h6, 16'd0, 32'h0, 1'b1, 1'b1, 4'h9);
    readCmd(cmd, got);
    check("R7 collision port 0 wins", got, expOf(cmd, 32'h11112222, 32'h0));

    // R7: read during write returns old data
    cmd = mkFrame(4'd2, 16'd4, 32'h89ABCDEF, 1'b0, 1'b0, 4'h2, 16'd4, 32'h0, 1'b0, 1'b1, 4'h3);
    readCmd(cmd, got);
    check("R7 read during write old data", got, expOf(cmd, 32'h0, 32'h11112222));
    cmd = mkFrame(4'd2, 16'd0, 32'h0, 1'b1, 1'b1, 4'h8, 16'd4, 32'h0, 1'b0, 1'b1, 4'h1);
    readCmd(cmd, got);
    check("R7 write landed", got, expOf(cmd, 32'h0, 32'h89ABCDEF));

    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule